// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block runs one sampling cycle of an external 12-bit converter that has a serial output. The converter is wired to it through four lines: an active-low convert-start output, a busy input, a serial clock output and a serial data input. A single-cycle start request makes the controller drive convert-start low for a set number of system clocks, which starts the conversion and fixes the sample instant. The controller then waits for busy to go high and come back low. After that it runs the serial clock for exactly sixteen periods and shifts in one frame.

A frame holds four zero bits followed by twelve result bits, most significant bit first. The converter launches each bit on a falling serial clock edge and keeps the old bit valid for a short hold time, so the controller takes each bit on that same falling edge. The twelve data bits go out on a result bus with a one-cycle valid strobe. The converter's native coding is fixed by a parameter, and an input selects whether the result is given in two's complement or straight binary. A flag reports a frame whose four leading bits are not all zero. A second flag reports a conversion that never completed.

With the power-down input set, convert-start stays low past the end of the conversion, so the converter sleeps between samples. The next start request first raises convert-start to wake the converter, waits a set number of clocks for it to power up, and then begins a new conversion.

Top module: `serial_adc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, convert-start is high, the serial clock is low, the valid strobe is low and the timeout flag is low.
- R2: A start request accepted while the converter is awake drives convert-start low for exactly CONV_LOW system clocks. When power-down is off, convert-start then returns high.
- R3: The serial clock stays low until busy has been seen high and then low, and it never rises while busy is high.
- R4: A read frame has exactly 16 serial clock periods. Each high phase and each low phase lasts SCLK_HALF system clocks. The serial clock is low between frames and after the 16th falling edge.
- R5: Serial data is sampled on each falling serial clock edge, first bit first. The last 12 bits of the 16, MSB first, form the result.
- R6: The valid strobe is high for one system clock after the 16th falling edge. The result stays unchanged afterwards, with the strobe low, until the next frame.
- R7: When the output-coding input (1 = two's complement, 0 = straight binary) differs from the converter's native coding parameter SRC_TWOS, result bit 11 is inverted. Otherwise the 12 bits pass through unchanged.
- R8: The frame-error flag, valid with the strobe, is 1 exactly when any of the first four received bits is 1.
- R9: If busy has not completed its high-then-low cycle within TIMEOUT clocks after the convert-start pulse ends, the timeout flag is set, no frame is read and no strobe is given. The next accepted start clears the flag.
- R10: With power-down set, convert-start stays low from the start of the conversion through the read and while the controller is idle afterwards.
- R11: A start request while the converter is asleep drives convert-start high for exactly WAKE_WAIT clocks and then low to begin a conversion.
- R12: Start requests made during a conversion or read are ignored. Each accepted start gives exactly one convert-start falling edge and at most one strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request to sample |
| pd_mode | input | 1 | 1 = power the converter down after each conversion |
| out_twos | input | 1 | Output coding: 1 = two's complement, 0 = straight binary |
| busy | input | 1 | Converter busy line (asynchronous) |
| sdata | input | 1 | Converter serial data |
| cnvst_n | output | 1 | Active-low convert-start to the converter |
| sclk | output | 1 | Serial clock to the converter |
| result | output | DATA_W | Latest 12-bit result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| frame_err | output | 1 | Leading bits of the latest frame were not all zero |
| timeout_err | output | 1 | Last conversion did not complete in time |

## Verification
A sequencer stuck in the wrong state shows up at the pins within one conversion. The convert-start low or wake width comes out wrong, or the serial clock starts while busy is still high, or a second convert-start edge appears after a start that should have been ignored. A bit counter that is off by one gives a frame with 15 or 17 clock rises and shifts the result by one bit. This is seen at the very next strobe. A coding or framing fault appears as a wrong result bit 11 or a wrong error flag in the same cycle as the strobe. A broken timeout counter shows as a flag that is early, late or missing within TIMEOUT clocks of a converter that stays busy.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAKE = 3'd1,
    ST_CONV = 3'd2,
    ST_WAIT = 3'd3,
    ST_READ = 3'd4,
    ST_DONE = 3'd5
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adcc_sclk_gen.sv
module adcc_sclk_gen #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic fall
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!en) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
  assign fall = en && sclk_q && wrap;

  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk_q);

endmodule

// File: rtl/adcc_shifter.sv
module adcc_shifter #(
  parameter int unsigned BITS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift,
  input  logic            din,
  output logic [BITS-1:0] data,
  output logic            last
);
  localparam int CW = $clog2(BITS + 1);

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [BITS-1:0] data_q, data_d;
  logic            data_en;

  always_comb begin
    cnt_d   = cnt_q;
    data_en = shift;
    data_d  = {data_q[BITS-2:0], din};
    if (clr)        cnt_d = '0;
    else if (shift) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign data = data_q;
  assign last = shift && (cnt_q == CW'(BITS - 1));

  p_no_extra_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (cnt_q < CW'(BITS)));

endmodule

// File: rtl/adcc_seq.sv
module adcc_seq
  import adcc_pkg::*;
#(
  parameter int unsigned CONV_LOW  = 4,
  parameter int unsigned TIMEOUT   = 400,
  parameter int unsigned WAKE_WAIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic pd_mode,
  input  logic busy_async,
  input  logic frame_last,
  output logic cnvst_n,
  output logic sclk_en,
  output logic rd_start,
  output logic done,
  output logic timeout_err
);
  localparam int unsigned TMAX = max3(CONV_LOW, TIMEOUT, WAKE_WAIT);
  localparam int TW = $clog2(TMAX + 1);

  seq_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [1:0]    busy_sync;
  logic          busy_s;
  logic          seen_q, seen_d;
  logic          asleep_q, asleep_d;
  logic          tout_q, tout_d;
  logic          cnvst_q, cnvst_d;

  assign busy_s = busy_sync[1];

  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_q;
    seen_d   = seen_q;
    asleep_d = asleep_q;
    tout_d   = tout_q;
    sclk_en  = 1'b0;
    rd_start = 1'b0;
    done     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        tmr_d = '0;
        if (start_req) begin
          tout_d  = 1'b0;
          seen_d  = 1'b0;
          state_d = asleep_q ? ST_WAKE : ST_CONV;
        end
      end
      ST_WAKE: begin
        if (tmr_q == TW'(WAKE_WAIT - 1)) begin
          tmr_d    = '0;
          asleep_d = 1'b0;
          state_d  = ST_CONV;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_CONV: begin
        if (busy_s) seen_d = 1'b1;
        if (tmr_q == TW'(CONV_LOW - 1)) begin
          tmr_d   = '0;
          state_d = ST_WAIT;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (busy_s) seen_d = 1'b1;
        if (seen_q && !busy_s) begin
          rd_start = 1'b1;
          asleep_d = pd_mode;
          tmr_d    = '0;
          state_d  = ST_READ;
        end else if (tmr_q == TW'(TIMEOUT - 1)) begin
          tout_d   = 1'b1;
          asleep_d = pd_mode;
          tmr_d    = '0;
          state_d  = ST_IDLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_READ: begin
        sclk_en = 1'b1;
        if (frame_last) state_d = ST_DONE;
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_WAKE: cnvst_d = 1'b1;
      ST_CONV: cnvst_d = 1'b0;
      ST_WAIT: cnvst_d = !pd_mode;
      default: cnvst_d = !asleep_d;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tmr_q     <= '0;
      busy_sync <= '0;
      seen_q    <= 1'b0;
      asleep_q  <= 1'b0;
      tout_q    <= 1'b0;
      cnvst_q   <= 1'b1;
    end else begin
      state_q   <= state_d;
      tmr_q     <= tmr_d;
      busy_sync <= {busy_sync[0], busy_async};
      seen_q    <= seen_d;
      asleep_q  <= asleep_d;
      tout_q    <= tout_d;
      cnvst_q   <= cnvst_d;
    end
  end

  assign cnvst_n     = cnvst_q;
  assign timeout_err = tout_q;

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_read_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> (seen_q && !busy_s));

  p_wake_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE) |-> cnvst_n);

  generate
    if (CONV_LOW >= 2) begin : g_low_chk
      p_cnvst_min_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnvst_q) |=> !cnvst_q);
    end
  endgenerate

endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl
  import adcc_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 4,
  parameter int unsigned CONV_LOW  = 4,
  parameter int unsigned TIMEOUT   = 400,
  parameter int unsigned WAKE_WAIT = 32,
  parameter bit          SRC_TWOS  = 1'b1,
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned LEAD_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              pd_mode,
  input  logic              out_twos,
  input  logic              busy,
  input  logic              sdata,
  output logic              cnvst_n,
  output logic              sclk,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              frame_err,
  output logic              timeout_err
);
  localparam int unsigned FRAME_W = DATA_W + LEAD_W;

  logic               sclk_en, sclk_fall, rd_start, frame_last, done;
  logic [FRAME_W-1:0] raw;
  logic               flip_msb;

  adcc_seq #(
    .CONV_LOW (CONV_LOW),
    .TIMEOUT  (TIMEOUT),
    .WAKE_WAIT(WAKE_WAIT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .pd_mode    (pd_mode),
    .busy_async (busy),
    .frame_last (frame_last),
    .cnvst_n    (cnvst_n),
    .sclk_en    (sclk_en),
    .rd_start   (rd_start),
    .done       (done),
    .timeout_err(timeout_err)
  );

  adcc_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (sclk_en),
    .sclk (sclk),
    .fall (sclk_fall)
  );

  adcc_shifter #(.BITS(FRAME_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (rd_start),
    .shift(sclk_fall),
    .din  (sdata),
    .data (raw),
    .last (frame_last)
  );

  assign flip_msb     = (out_twos != SRC_TWOS);
  assign result       = {raw[DATA_W-1] ^ flip_msb, raw[DATA_W-2:0]};
  assign frame_err    = |raw[FRAME_W-1:DATA_W];
  assign result_valid = done;

  p_sclk_quiet_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sclk);

  p_timeout_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !result_valid);

  p_no_sclk_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnvst_n && !pd_mode |-> !sclk);

endmodule

// File: tb/serial_adc_ctrl_bench.sv
module serial_adc_ctrl_bench;
  localparam int H = 2, CL = 3, TO = 60, WW = 5;
  localparam int PER = 8;

  typedef struct {
    logic [11:0] res;
    logic        ferr;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start_req, pd_mode, out_twos, busy, sdata;
  logic cnvst_n, sclk, result_valid, frame_err, timeout_err;
  logic [11:0] result;

  int checks = 0, failures = 0;
  int n_valid = 0, n_falls = 0, rises = 0, phase_bad = 0, busy_bad = 0;
  bit got_rise = 0;
  time t_rise = 0;
  logic [15:0] frame_word = 16'h0;
  bit hang = 0;
  int conv_clks = 20;
  int bidx = 16;
  bit finished = 0;
  exp_t q[$];

  serial_adc_ctrl #(
    .SCLK_HALF(H), .CONV_LOW(CL), .TIMEOUT(TO), .WAKE_WAIT(WW), .SRC_TWOS(1'b1)
  ) u_serial_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .pd_mode(pd_mode),
    .out_twos(out_twos), .busy(busy), .sdata(sdata), .cnvst_n(cnvst_n),
    .sclk(sclk), .result(result), .result_valid(result_valid),
    .frame_err(frame_err), .timeout_err(timeout_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // converter model: busy on convert-start fall, data launched on sclk falls
  assign sdata = (bidx >= 0 && bidx < 16) ? frame_word[15-bidx] : 1'b1;

  initial begin
    busy = 1'b0;
    forever begin
      @(negedge cnvst_n);
      #1;
      busy = 1'b1;
      bidx = 0;
      if (hang) wait (hang == 0);
      else repeat (conv_clks) @(posedge clk);
      #1 busy = 1'b0;
    end
  end

  always @(negedge sclk) begin
    #1 bidx = bidx + 1;
  end

  always @(negedge cnvst_n) n_falls++;

  always @(posedge sclk) begin
    rises++;
    if (busy) busy_bad++;
    if (got_rise && (($time - t_rise) != 2 * H * PER)) phase_bad++;
    t_rise = $time;
    got_rise = 1;
  end

  always @(negedge sclk) begin
    if (got_rise && (($time - t_rise) != H * PER)) phase_bad++;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && result_valid === 1'b1) begin
      n_valid++;
      if (q.size() == 0) begin
        chk(0, "R12 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(result == e.res, "R5/R7 result", int'(result), int'(e.res));
        chk(frame_err == e.ferr, "R8 frame_err", int'(frame_err), int'(e.ferr));
        chk(rises == 16, "R4 sclk rises per frame", rises, 16);
        chk(phase_bad == 0, "R4 sclk phase width", phase_bad, 0);
        chk(busy_bad == 0, "R3 sclk while busy", busy_bad, 0);
        chk(timeout_err == 1'b0, "R9 flag cleared", int'(timeout_err), 0);
      end
      rises = 0;
      got_rise = 0;
      phase_bad = 0;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic run_conv(input logic [15:0] w, input logic otw, input bit wake, input bit pdm);
    exp_t e;
    int nv0, nf0, hi, lo;
    bit got;
    frame_word = w;
    out_twos = otw;
    e.res = w[11:0] ^ ((otw != 1'b1) ? 12'h800 : 12'h000);
    e.ferr = |w[15:12];
    q.push_back(e);
    nv0 = n_valid;
    nf0 = n_falls;
    pulse_start();
    if (wake) begin
      hi = 0;
      while (cnvst_n && hi < 1000) begin hi++; @(negedge clk); end
      chk(hi == WW, "R11 wake width", hi, WW);
    end
    if (!pdm) begin
      lo = 0;
      while (!cnvst_n && lo < 1000) begin lo++; @(negedge clk); end
      chk(lo == CL, "R2 convert-start width", lo, CL);
    end
    pulse_start();  // R12: request during conversion must be ignored
    got = 0;
    for (int i = 0; i < 2000 && !got; i++) begin
      @(negedge clk);
      if (n_valid != nv0) got = 1;
    end
    chk(got, "R6 strobe seen", int'(got), 1);
    repeat (30) @(negedge clk);
    chk(n_falls == nf0 + 1, "R12 one convert-start edge", n_falls - nf0, 1);
    chk(n_valid == nv0 + 1, "R12 one strobe", n_valid - nv0, 1);
    chk(result == e.res && !result_valid, "R6 result held", int'(result), int'(e.res));
    chk(sclk == 1'b0, "R4 sclk idle low", int'(sclk), 0);
  endtask

  initial begin
    int nv0;
    rst_n = 1'b0; start_req = 1'b0; pd_mode = 1'b0; out_twos = 1'b1;
    repeat (3) @(negedge clk);
    chk(cnvst_n == 1'b1, "R1 cnvst_n in reset", int'(cnvst_n), 1);
    chk(sclk == 1'b0, "R1 sclk in reset", int'(sclk), 0);
    chk(result_valid == 1'b0, "R1 valid in reset", int'(result_valid), 0);
    chk(timeout_err == 1'b0, "R1 timeout in reset", int'(timeout_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cnvst_n == 1'b1 && sclk == 1'b0, "R1 after release", int'({cnvst_n, sclk}), 2);

    run_conv(16'h0ABC, 1'b1, 0, 0);
    run_conv(16'h0FFF, 1'b1, 0, 0);
    run_conv(16'h0000, 1'b0, 0, 0);
    run_conv(16'h0800, 1'b0, 0, 0);
    run_conv(16'h0555, 1'b1, 0, 0);
    run_conv(16'h37A5, 1'b1, 0, 0);   // R8 leading bits set
    run_conv(16'h8001, 1'b0, 0, 0);   // R8 top bit only

    // R9: converter never completes
    hang = 1;
    nv0 = n_valid;
    pulse_start();
    repeat (CL + TO / 2) @(negedge clk);
    chk(timeout_err == 1'b0, "R9 not early", int'(timeout_err), 0);
    repeat (TO) @(negedge clk);
    chk(timeout_err == 1'b1, "R9 flag set", int'(timeout_err), 1);
    chk(n_valid == nv0, "R9 no strobe", n_valid - nv0, 0);
    chk(rises == 0, "R9 no frame read", rises, 0);
    hang = 0;
    repeat (10) @(negedge clk);
    run_conv(16'h0123, 1'b1, 0, 0);

    // R10 / R11: power-down
    pd_mode = 1'b1;
    run_conv(16'h0A5A, 1'b1, 0, 1);
    repeat (20) @(negedge clk);
    chk(cnvst_n == 1'b0, "R10 held low while idle", int'(cnvst_n), 0);
    run_conv(16'h0F0F, 1'b0, 1, 1);
    chk(cnvst_n == 1'b0, "R10 low after read", int'(cnvst_n), 0);
    pd_mode = 1'b0;
    run_conv(16'h0321, 1'b1, 1, 0);
    chk(cnvst_n == 1'b1, "R2 awake idle high", int'(cnvst_n), 1);
    run_conv(16'h0777, 1'b0, 0, 0);

    chk(q.size() == 0, "R12 all results seen", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule